// File: doc/BRIEF.md
# Double-Buffered Slot Control Map Store

This block keeps two copies of a per-slot control map, each entry 9 bits wide and at most 1024 entries long. One copy is live: a frame sequencer walks it one word per time slot. The other copy is parked on the host side, where the host loads it word by word and reads it back through a data port. The host drives the block through a 3-bit control field written with a strobe.

Once a new map is loaded, the host asks for a swap. The request is held until the next frame-start pulse, so a frame always runs from one map. At that boundary the loaded copy goes live, and the copy that was live becomes the host-side copy. The last word of each map goes into its own register rather than into the storage array. Both readers see it at the final position.

Top module: `ppmap_buffer`

## Requirements
- R1: After reset, `active_sel` is 0 (copy 0 live, copy 1 on the host side), `swap_pending` is 0 and `overflow` is 0.
- R2: Host writes fill the host-side copy in order from position 0. `host_rdata` always shows the word at the host read position. Each `host_rd` pulse advances that position, and after the final position it wraps to 0.
- R3: The word written at position DEPTH-1 goes into that copy's last-word register, not the array. Both the host port and the sequencer return it at position DEPTH-1.
- R4: A host write after DEPTH words is dropped, and stored words are unchanged. It sets `overflow`, which stays set until a buffer reset or a swap.
- R5: A `ctl_wr` with `ctl_bits[0]` (buffer reset) set clears both host pointers and `overflow`. The next write lands at position 0 and the next read returns position 0.
- R6: A `ctl_wr` with `ctl_bits[1]` (retransmit) set clears only the host read pointer. Writing continues where it was.
- R7: A `ctl_wr` with `ctl_bits[2]` (switch) set raises `swap_pending`. `active_sel` does not change until a `frame_start` pulse. At that edge `active_sel` toggles and `swap_pending` clears.
- R8: A `frame_start` with no pending switch leaves `active_sel` unchanged.
- R9: `slot_word` is the live copy's word at the slot position. `frame_start` returns the slot position to 0. `slot_adv` advances it by one and holds it at DEPTH-1.
- R10: A swap clears both host pointers and `overflow`. After the swap, host accesses go to the copy that was just live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 9 | Host write word |
| host_rd | input | 1 | Host read advance strobe |
| host_rdata | output | 9 | Word at the host read position |
| ctl_wr | input | 1 | Control field strobe |
| ctl_bits | input | 3 | bit0 reset, bit1 retransmit, bit2 switch |
| frame_start | input | 1 | Frame boundary pulse |
| slot_adv | input | 1 | Advance to next slot |
| slot_word | output | 9 | Live copy word for current slot |
| active_sel | output | 1 | Index of the live copy |
| swap_pending | output | 1 | Switch requested, not yet taken |
| overflow | output | 1 | Write attempted past a full map |

## Verification
The bench loads a full map, reads it back and walks it live. It targets the final position: a design that stored the last word in the array, or read from the wrong source, would return a stale or undefined word in the last slot. It writes past a full map; a faulty design would overwrite the last word or leave `overflow` low. It also mixes retransmit with buffer reset, where clearing the wrong pointer makes read-back return the wrong word. Finally it sends frame pulses with and without a pending switch, where a design that swapped at once or on every frame would show the wrong `active_sel` or wrong slot data.

// File: rtl/ppmap_pkg.sv
package ppmap_pkg;
  // host control field, bit 0 at the right
  typedef struct packed {
    logic swap;
    logic retx;
    logic clr;
  } ctl_t;
endpackage

// File: rtl/ppmap_bank.sv
module ppmap_bank #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [WORD_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [WORD_W-1:0] rd_data_b
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH-1];
  logic [WORD_W-1:0] last_q;
  logic [WORD_W-1:0] last_d;
  logic              mem_we;
  logic              last_we;

  always_comb begin
    mem_we  = wr_en && (wr_addr != LAST);
    last_we = wr_en && (wr_addr == LAST);
    last_d  = last_we ? wr_data : last_q;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  always_comb begin
    rd_data_a = (rd_addr_a == LAST) ? last_q : mem_q[rd_addr_a];
    rd_data_b = (rd_addr_b == LAST) ? last_q : mem_q[rd_addr_b];
  end
endmodule

// File: rtl/ppmap_host_ctl.sv
module ppmap_host_ctl #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              ctl_wr,
  input  ppmap_pkg::ctl_t   ctl,
  input  logic              frame_start,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              active_sel,
  output logic              swap_pending,
  output logic              overflow
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] wp_q, wp_d;
  logic [AW-1:0] rp_q, rp_d;
  logic          ovf_q, ovf_d;
  logic          pend_q, pend_d;
  logic          act_q, act_d;
  logic          do_clr, do_retx, do_req, swap_now, full;

  always_comb begin
    do_clr   = ctl_wr && ctl.clr;
    do_retx  = ctl_wr && ctl.retx;
    do_req   = ctl_wr && ctl.swap;
    swap_now = frame_start && pend_q;
    full     = (wp_q == FULL);
    wr_en    = host_wr && !do_clr && !full;

    wp_d = wp_q;
    if (wr_en) wp_d = wp_q + PW'(1);
    if (do_clr || swap_now) wp_d = '0;

    rp_d = rp_q;
    if (host_rd && !do_clr && !do_retx)
      rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    if (do_clr || do_retx || swap_now) rp_d = '0;

    ovf_d = ovf_q;
    if (host_wr && !do_clr && full) ovf_d = 1'b1;
    if (do_clr || swap_now) ovf_d = 1'b0;

    pend_d = pend_q;
    if (swap_now) pend_d = 1'b0;
    if (do_req)   pend_d = 1'b1;

    act_d = swap_now ? !act_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign wr_addr      = wp_q[AW-1:0];
  assign rd_addr      = rp_q;
  assign active_sel   = act_q;
  assign swap_pending = pend_q;
  assign overflow     = ovf_q;

  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_q) |=> (act_q != $past(act_q)));
  assert_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_req |=> pend_q);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start || !pend_q) |=> $stable(act_q));
  assert_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && full && !do_clr && !swap_now) |=> ovf_q);
  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (wp_q == '0 && rp_q == '0 && !ovf_q));
endmodule

// File: rtl/ppmap_seq.sv
module ppmap_seq #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          slot_adv,
  output logic [AW-1:0] slot_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (slot_adv && sp_q != LAST) sp_d = sp_q + AW'(1);
    if (frame_start) sp_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign slot_addr = sp_q;

  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sp_q == '0));
  assert_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && sp_q == LAST) |=> (sp_q == LAST));
endmodule

// File: rtl/ppmap_buffer.sv
module ppmap_buffer #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_bits,
  input  logic              frame_start,
  input  logic              slot_adv,
  output logic [WORD_W-1:0] slot_word,
  output logic              active_sel,
  output logic              swap_pending,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic              host_we;
  logic [AW-1:0]     host_waddr;
  logic [AW-1:0]     host_raddr;
  logic [AW-1:0]     slot_addr;
  logic [WORD_W-1:0] rd_a [2];
  logic [WORD_W-1:0] rd_b [2];

  ppmap_host_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) host_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .ctl_wr       (ctl_wr),
    .ctl          (ppmap_pkg::ctl_t'(ctl_bits)),
    .frame_start  (frame_start),
    .wr_en        (host_we),
    .wr_addr      (host_waddr),
    .rd_addr      (host_raddr),
    .active_sel   (active_sel),
    .swap_pending (swap_pending),
    .overflow     (overflow)
  );

  ppmap_seq #(.DEPTH(DEPTH), .AW(AW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .slot_adv    (slot_adv),
    .slot_addr   (slot_addr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ppmap_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (host_we && (active_sel != 1'(b))),
      .wr_addr   (host_waddr),
      .wr_data   (host_wdata),
      .rd_addr_a (host_raddr),
      .rd_data_a (rd_a[b]),
      .rd_addr_b (slot_addr),
      .rd_data_b (rd_b[b])
    );
  end

  assign host_rdata = rd_a[!active_sel];
  assign slot_word  = rd_b[active_sel];
endmodule

// File: tb/ppmap_buffer_tb.sv
module ppmap_buffer_tb_top;
  localparam int W = 9;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr = 1'b0, host_rd = 1'b0, ctl_wr = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [2:0]   ctl_bits = '0;
  logic         frame_start = 1'b0, slot_adv = 1'b0;
  logic [W-1:0] host_rdata, slot_word;
  logic         active_sel, swap_pending, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = !clk;

  ppmap_buffer #(.WORD_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .ctl_wr(ctl_wr),
    .ctl_bits(ctl_bits), .frame_start(frame_start), .slot_adv(slot_adv),
    .slot_word(slot_word), .active_sel(active_sel),
    .swap_pending(swap_pending), .overflow(overflow)
  );

  // op: 0 write, 1 check host read then advance, 2 control, 3 frame, 4 check slot then advance
  localparam int NV = 30;
  localparam logic [11:0] VEC [NV] = '{
    {3'd2, 9'h001},
    {3'd0, 9'h101}, {3'd0, 9'h102}, {3'd0, 9'h103}, {3'd0, 9'h104},
    {3'd0, 9'h105}, {3'd0, 9'h106}, {3'd0, 9'h107}, {3'd0, 9'h108},
    {3'd2, 9'h002},
    {3'd1, 9'h101}, {3'd1, 9'h102}, {3'd1, 9'h103}, {3'd1, 9'h104},
    {3'd1, 9'h105}, {3'd1, 9'h106}, {3'd1, 9'h107}, {3'd1, 9'h108},
    {3'd1, 9'h101},
    {3'd2, 9'h004}, {3'd3, 9'h000},
    {3'd4, 9'h101}, {3'd4, 9'h102}, {3'd4, 9'h103}, {3'd4, 9'h104},
    {3'd4, 9'h105}, {3'd4, 9'h106}, {3'd4, 9'h107}, {3'd4, 9'h108},
    {3'd4, 9'h108}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic rd();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask
  task automatic ctl(input logic [2:0] b);
    @(negedge clk); ctl_wr = 1'b1; ctl_bits = b;
    @(negedge clk); ctl_wr = 1'b0; ctl_bits = '0;
  endtask
  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask
  task automatic slot();
    @(negedge clk); slot_adv = 1'b1;
    @(negedge clk); slot_adv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 active_sel", W'(active_sel), 9'h0);
    check("R1 swap_pending", W'(swap_pending), 9'h0);
    check("R1 overflow", W'(overflow), 9'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][11:9])
        3'd0: wr(VEC[i][8:0]);
        3'd1: begin check("R2 R3 host read", host_rdata, VEC[i][8:0]); rd(); end
        3'd2: ctl(VEC[i][2:0]);
        3'd3: frame();
        default: begin check("R9 R3 slot word", slot_word, VEC[i][8:0]); slot(); end
      endcase
    end
    check("R7 swap taken", W'(active_sel), 9'h1);

    // R8: frame with nothing pending, and R9 slot reset
    frame();
    check("R8 no swap", W'(active_sel), 9'h1);
    check("R9 slot reset", slot_word, 9'h101);
    slot(); slot(); slot();
    check("R9 slot advance", slot_word, 9'h104);
    frame();
    check("R9 mid-frame reset", slot_word, 9'h101);

    // R4: load copy 0, then one write too many
    ctl(3'b001);
    for (int i = 0; i < D; i++) wr(W'(9'h0A0 + i));
    check("R4 no overflow yet", W'(overflow), 9'h0);
    wr(9'h1FF);
    check("R4 overflow set", W'(overflow), 9'h1);
    ctl(3'b010);
    for (int i = 0; i < D - 1; i++) rd();
    check("R3 R4 last word kept", host_rdata, 9'h0A7);

    // R7: pending held until frame
    ctl(3'b100);
    check("R7 pending", W'(swap_pending), 9'h1);
    repeat (3) @(negedge clk);
    check("R7 no early swap", W'(active_sel), 9'h1);
    frame();
    check("R7 swapped", W'(active_sel), 9'h0);
    check("R7 pending cleared", W'(swap_pending), 9'h0);

    // R10: host now sees previous live copy
    check("R10 host view", host_rdata, 9'h101);
    check("R10 overflow cleared", W'(overflow), 9'h0);
    check("R9 new live map", slot_word, 9'h0A0);
    for (int i = 0; i < D - 1; i++) slot();
    check("R3 last slot", slot_word, 9'h0A7);

    // R6: retransmit leaves write pointer
    wr(9'h011); wr(9'h022);
    ctl(3'b010);
    wr(9'h033);
    check("R6 read 0", host_rdata, 9'h011);
    rd();
    check("R6 read 1", host_rdata, 9'h022);
    rd();
    check("R6 read 2", host_rdata, 9'h033);

    // R5: reset clears both pointers
    rd();
    ctl(3'b001);
    wr(9'h055);
    check("R5 both pointers", host_rdata, 9'h055);
    check("R5 overflow", W'(overflow), 9'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule